// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Unit

This unit pulls one instruction out of a character-addressed memory in which instructions have no fixed size. Each memory character carries a data value and a field-end marker bit. Starting at its instruction pointer, the unit reads characters in ascending address order. The first character is the opcode. It then collects up to two operand addresses and an optional trailing modifier. The instruction ends at the first later character whose marker bit is set, and that terminating character is not consumed.

From the number of characters collected, the unit decides which fields are present. Any field that is absent is taken from the value used by the previous instruction (chaining). When the instruction is well formed, the unit presents the opcode, both addresses and the modifier with a one-cycle valid strobe, and it moves the instruction pointer onto the terminating character. An opcode without a marker, a count that matches no field layout, or a run of characters that is too long raises a one-cycle length error instead. For a configurable set of I/O opcodes, the first address is a short 3-character channel/device field.

Top module: `ifu_fetch_unit`

## Requirements
- R1: The character at the instruction pointer must carry a set marker bit. If it does not, the unit pulses `lenError` two cycles after the start edge, and it leaves the pointer and all result fields unchanged.
- R2: A fetch ends at the first character after the opcode whose marker bit is set. The collected count n is that character's distance from the pointer. On a valid fetch, `ip` becomes pointer + n, which is the terminator's own address.
- R3: For an ordinary opcode, counts are decoded as follows: 1 means opcode only; 6 means A; 7 means A plus modifier; 11 means A and B; 12 means A, B and modifier. Each address is 5 characters of 6 bits, and the character at the lowest address is the most significant. The modifier is the last character collected.
- R4: Opcode values 20 and 36 are I/O opcodes. For these the A field is 3 characters, and the valid counts are 1, 4, 5, 9 and 10. The A value is right-aligned in the low 18 bits with the upper 12 bits zero. The count 6 is invalid for an I/O opcode.
- R5: On a valid fetch, every field that is absent keeps the value that the same output last presented (chaining). Present fields replace those values.
- R6: A count that fits no layout pulses `lenError` instead of `instValid`. The pointer and all field outputs are left unchanged, and the two strobes are never high together.
- R7: If 12 characters after the opcode are read and none of them is marked, the unit pulses `lenError` after its 13th read. It never reads further.
- R8: One memory read is issued every other cycle, at address pointer + k for the k-th character. For a fetch that decides on character n, the result strobe is high for exactly one cycle, 2n+2 cycles after the start edge, and `busy` is high until then.
- R9: `ipLoad` loads `ipLoadValue` into the pointer only while the unit is idle. A load request during a fetch is ignored.
- R10: After reset, the pointer is 0, both strobes and `busy` are low, and all field outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchStart | input | 1 | Begin a fetch at the current pointer (idle only) |
| ipLoad | input | 1 | Load the pointer from `ipLoadValue` |
| ipLoadValue | input | ADDR_W | New pointer value |
| memRead | output | 1 | Memory read request |
| memAddr | output | ADDR_W | Character address of the read |
| memChar | input | CHAR_W | Character data, valid the cycle after the request |
| memMark | input | 1 | Marker bit of that character |
| busy | output | 1 | Fetch in progress |
| instValid | output | 1 | One-cycle strobe: fields hold a new instruction |
| lenError | output | 1 | One-cycle strobe: malformed instruction |
| instOp | output | CHAR_W | Opcode |
| instAddrA | output | ADDR_CHARS*CHAR_W | A address, current or chained |
| instAddrB | output | ADDR_CHARS*CHAR_W | B address, current or chained |
| instMod | output | CHAR_W | Modifier, current or chained |
| ip | output | ADDR_W | Instruction pointer |

## Verification
The bench walks a chain of instructions that exercises every legal count for both ordinary and I/O opcodes. After an opcode-only instruction, it expects every field to have been inherited. A decoder that mixed up the A and B boundaries for the short I/O address, or that took the modifier from a fixed slot, would show wrong field values here. The bench also covers an I/O count that is legal only for ordinary opcodes, an unmarked opcode and an unterminated run. In each of these, a faulty design would emit a valid strobe, move the pointer or read a 14th character. Finally, the bench requests a pointer load in the middle of a fetch. A design that honoured that load would finish at the wrong pointer.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
  typedef struct packed {
    logic clrCnt;
    logic takeOp;
    logic takeBody;
    logic commit;
    logic fail;
    logic acceptLoad;
  } ifuStrobe_t;
endpackage

// File: rtl/ifu_ctrl.sv
module ifu_ctrl
  import ifu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fetchStart,
  input  logic       ipLoad,
  input  logic       memMark,
  input  logic       cntZero,
  input  logic       cntAtMax,
  input  logic       lenOk,
  output ifuStrobe_t str,
  output logic       memRead,
  output logic       busy
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_CHK} state_t;
  state_t state, stateNext;

  always_comb begin
    str = '0;
    memRead = 1'b0;
    stateNext = state;
    unique case (state)
      S_IDLE: begin
        str.acceptLoad = ipLoad;
        if (fetchStart) begin
          str.clrCnt = 1'b1;
          stateNext = S_REQ;
        end
      end
      S_REQ: begin
        memRead = 1'b1;
        stateNext = S_CHK;
      end
      S_CHK: begin
        if (cntZero) begin
          if (memMark) begin
            str.takeOp = 1'b1;
            stateNext = S_REQ;
          end else begin
            str.fail = 1'b1;
            stateNext = S_IDLE;
          end
        end else if (memMark) begin
          str.commit = lenOk;
          str.fail = !lenOk;
          stateNext = S_IDLE;
        end else if (cntAtMax) begin
          str.fail = 1'b1;
          stateNext = S_IDLE;
        end else begin
          str.takeBody = 1'b1;
          stateNext = S_REQ;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state != S_IDLE);

  AST_READ_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    memRead |=> !memRead) else $error("read issued back to back"); // R8
  AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !str.acceptLoad) else $error("pointer load accepted while busy"); // R9
endmodule

// File: rtl/ifu_datapath.sv
module ifu_datapath
  import ifu_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int CHAR_W     = 6,
  parameter int ADDR_CHARS = 5,
  parameter int IO_CHARS   = 3,
  parameter logic [(1<<CHAR_W)-1:0] IO_OP_MASK = 64'h0000_0010_0010_0000,
  parameter logic [ADDR_W-1:0] RESET_IP = '0
)(
  input  logic                         clk,
  input  logic                         rstN,
  input  ifuStrobe_t                   str,
  input  logic [ADDR_W-1:0]            ipLoadValue,
  input  logic [CHAR_W-1:0]            memChar,
  output logic [ADDR_W-1:0]            memAddr,
  output logic                         cntZero,
  output logic                         cntAtMax,
  output logic                         lenOk,
  output logic [ADDR_W-1:0]            ip,
  output logic                         instValid,
  output logic                         lenError,
  output logic [CHAR_W-1:0]            instOp,
  output logic [ADDR_CHARS*CHAR_W-1:0] instAddrA,
  output logic [ADDR_CHARS*CHAR_W-1:0] instAddrB,
  output logic [CHAR_W-1:0]            instMod
);
  localparam int BODY_CHARS = 2 * ADDR_CHARS + 1;
  localparam int MAX_CHARS  = BODY_CHARS + 1;
  localparam int CNT_W      = $clog2(MAX_CHARS + 1);
  localparam int FIELD_W    = ADDR_CHARS * CHAR_W;

  logic [ADDR_W-1:0] ipReg;
  logic [CNT_W-1:0]  cntReg;
  logic [CHAR_W-1:0] opReg;
  logic [CHAR_W-1:0] body [BODY_CHARS];

  logic isIo, hasA, hasB, hasMod;
  int aLen, nBody;
  logic [FIELD_W-1:0] fullA, ioA, fullB, ioB, newA, newB;
  logic [CHAR_W-1:0] newMod;

  assign isIo     = IO_OP_MASK[opReg];
  assign memAddr  = ipReg + ADDR_W'(cntReg);
  assign cntZero  = (cntReg == '0);
  assign cntAtMax = (cntReg == CNT_W'(MAX_CHARS));
  assign ip       = ipReg;

  always_comb begin
    aLen   = isIo ? IO_CHARS : ADDR_CHARS;
    nBody  = int'(cntReg) - 1;
    hasA   = (nBody >= aLen);
    hasB   = (nBody >= aLen + ADDR_CHARS);
    hasMod = (nBody == aLen + 1) || (nBody == aLen + ADDR_CHARS + 1);
    lenOk  = (nBody == 0) || (nBody == aLen) || hasMod || (nBody == aLen + ADDR_CHARS);
  end

  always_comb begin
    fullA = '0; ioA = '0; fullB = '0; ioB = '0; newMod = '0;
    for (int i = 0; i < ADDR_CHARS; i++) begin
      fullA[(ADDR_CHARS-1-i)*CHAR_W +: CHAR_W] = body[i];
      fullB[(ADDR_CHARS-1-i)*CHAR_W +: CHAR_W] = body[ADDR_CHARS+i];
      ioB[(ADDR_CHARS-1-i)*CHAR_W +: CHAR_W]   = body[IO_CHARS+i];
    end
    for (int i = 0; i < IO_CHARS; i++)
      ioA[(IO_CHARS-1-i)*CHAR_W +: CHAR_W] = body[i];
    for (int i = 0; i < BODY_CHARS; i++)
      if (i == nBody - 1) newMod = body[i];
    newA = isIo ? ioA : fullA;
    newB = isIo ? ioB : fullB;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ipReg     <= RESET_IP;
      cntReg    <= '0;
      opReg     <= '0;
      instValid <= 1'b0;
      lenError  <= 1'b0;
      instOp    <= '0;
      instAddrA <= '0;
      instAddrB <= '0;
      instMod   <= '0;
      for (int i = 0; i < BODY_CHARS; i++) body[i] <= '0;
    end else begin
      if (str.clrCnt) cntReg <= '0;
      else if (str.takeOp || str.takeBody) cntReg <= cntReg + CNT_W'(1);
      if (str.takeOp) opReg <= memChar;
      for (int i = 0; i < BODY_CHARS; i++)
        if (str.takeBody && cntReg == CNT_W'(i + 1)) body[i] <= memChar;
      instValid <= str.commit;
      lenError  <= str.fail;
      if (str.commit) begin
        instOp <= opReg;
        if (hasA)   instAddrA <= newA;
        if (hasB)   instAddrB <= newB;
        if (hasMod) instMod   <= newMod;
        ipReg <= ipReg + ADDR_W'(cntReg);
      end else if (str.acceptLoad) begin
        ipReg <= ipLoadValue;
      end
    end
  end

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    !(instValid && lenError)) else $error("valid and error together"); // R6
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    instValid |=> !instValid) else $error("valid longer than one cycle"); // R8
  AST_IP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!str.commit && !str.acceptLoad) |=> $stable(ipReg)) else $error("pointer moved"); // R9
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cntReg <= CNT_W'(MAX_CHARS)) else $error("count past limit"); // R7
endmodule

// File: rtl/ifu_fetch_unit.sv
module ifu_fetch_unit
  import ifu_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int CHAR_W     = 6,
  parameter int ADDR_CHARS = 5,
  parameter int IO_CHARS   = 3,
  parameter logic [(1<<CHAR_W)-1:0] IO_OP_MASK = 64'h0000_0010_0010_0000,
  parameter logic [ADDR_W-1:0] RESET_IP = '0
)(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         fetchStart,
  input  logic                         ipLoad,
  input  logic [ADDR_W-1:0]            ipLoadValue,
  output logic                         memRead,
  output logic [ADDR_W-1:0]            memAddr,
  input  logic [CHAR_W-1:0]            memChar,
  input  logic                         memMark,
  output logic                         busy,
  output logic                         instValid,
  output logic                         lenError,
  output logic [CHAR_W-1:0]            instOp,
  output logic [ADDR_CHARS*CHAR_W-1:0] instAddrA,
  output logic [ADDR_CHARS*CHAR_W-1:0] instAddrB,
  output logic [CHAR_W-1:0]            instMod,
  output logic [ADDR_W-1:0]            ip
);
  ifuStrobe_t str;
  logic cntZero, cntAtMax, lenOk;

  ifu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .fetchStart(fetchStart), .ipLoad(ipLoad),
    .memMark(memMark), .cntZero(cntZero), .cntAtMax(cntAtMax), .lenOk(lenOk),
    .str(str), .memRead(memRead), .busy(busy)
  );

  ifu_datapath #(
    .ADDR_W(ADDR_W), .CHAR_W(CHAR_W), .ADDR_CHARS(ADDR_CHARS),
    .IO_CHARS(IO_CHARS), .IO_OP_MASK(IO_OP_MASK), .RESET_IP(RESET_IP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .ipLoadValue(ipLoadValue),
    .memChar(memChar), .memAddr(memAddr), .cntZero(cntZero),
    .cntAtMax(cntAtMax), .lenOk(lenOk), .ip(ip), .instValid(instValid),
    .lenError(lenError), .instOp(instOp), .instAddrA(instAddrA),
    .instAddrB(instAddrB), .instMod(instMod)
  );
endmodule

// File: tb/ifu_fetch_unit_bench.sv
module ifu_fetch_unit_bench;
  localparam int AW = 17;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, fetchStart, ipLoad, memRead, memMark, busy, instValid, lenError;
  logic [AW-1:0] ipLoadValue, memAddr, ip;
  logic [5:0] memChar, instOp, instMod;
  logic [29:0] instAddrA, instAddrB;

  logic [5:0] memC [0:255];
  logic       memM [0:255];

  ifu_fetch_unit u_ifu_fetch_unit (
    .clk(clk), .rstN(rstN), .fetchStart(fetchStart), .ipLoad(ipLoad),
    .ipLoadValue(ipLoadValue), .memRead(memRead), .memAddr(memAddr),
    .memChar(memChar), .memMark(memMark), .busy(busy), .instValid(instValid),
    .lenError(lenError), .instOp(instOp), .instAddrA(instAddrA),
    .instAddrB(instAddrB), .instMod(instMod), .ip(ip)
  );

  always @(posedge clk)
    if (memRead) begin
      memChar <= memC[memAddr[7:0]];
      memMark <= memM[memAddr[7:0]];
    end

  int checks = 0;
  int fails = 0;
  int mIp;
  logic [29:0] mA, mB;
  logic [5:0] mOp, mMod;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic placeInst(input int base, input int op, input int nBody,
                           input int seed, input bit opMark, input bit term);
    memC[base] = 6'(op);
    memM[base] = opMark;
    for (int j = 0; j < nBody; j++) begin
      memC[base+1+j] = 6'(seed + 5*j + 1);
      memM[base+1+j] = 1'b0;
    end
    memM[base+1+nBody] = term;
  endtask

  task automatic loadIp(input int val);
    @(negedge clk); ipLoad = 1'b1; ipLoadValue = AW'(val);
    @(negedge clk); ipLoad = 1'b0;
    chk(ip == AW'(val), "R9", "pointer after idle load", ip, val);
    mIp = val;
  endtask

  task automatic runFetch(input string tag, input bit busyLoad);
    int n, al, nb, last, eIp;
    bit err, io;
    logic [29:0] eA, eB;
    logic [5:0] eOp, eMod;
    n = 0; err = 1'b0;
    if (!memM[mIp]) err = 1'b1;
    else begin
      for (int k = 1; k <= 12; k++)
        if (n == 0 && memM[mIp+k]) n = k;
      if (n == 0) begin err = 1'b1; n = 12; end
    end
    eOp = mOp; eA = mA; eB = mB; eMod = mMod; eIp = mIp;
    if (!err) begin
      io = (memC[mIp] == 6'd20) || (memC[mIp] == 6'd36);
      al = io ? 3 : 5;
      nb = n - 1;
      if (!(nb == 0 || nb == al || nb == al+1 || nb == al+5 || nb == al+6)) err = 1'b1;
      else begin
        eOp = memC[mIp];
        if (nb >= al) begin
          eA = '0;
          for (int i = 0; i < al; i++) eA = (eA << 6) | 30'(memC[mIp+1+i]);
        end
        if (nb >= al + 5) begin
          eB = '0;
          for (int i = 0; i < 5; i++) eB = (eB << 6) | 30'(memC[mIp+1+al+i]);
        end
        if (nb == al+1 || nb == al+6) eMod = memC[mIp+n-1];
        eIp = mIp + n;
      end
    end
    last = 2*n + 2;
    @(negedge clk); fetchStart = 1'b1;
    @(negedge clk); fetchStart = 1'b0;
    for (int c = 0; c <= last + 1; c++) begin
      if (c > 0) @(negedge clk);
      if (busyLoad && c == 3) begin ipLoad = 1'b1; ipLoadValue = AW'(200); end
      if (busyLoad && c == 4) ipLoad = 1'b0;
      chk(memRead == (c % 2 == 0 && c < last), "R8", "read request", memRead, (c % 2 == 0 && c < last));
      if (c % 2 == 0 && c < last)
        chk(memAddr == AW'(mIp + c/2), "R8", "read address", memAddr, mIp + c/2);
      chk(busy == (c < last), "R8", "busy", busy, c < last);
      chk(instValid == (c == last && !err), tag, "valid strobe", instValid, c == last && !err);
      chk(lenError == (c == last && err), err ? tag : "R6", "error strobe", lenError, c == last && err);
      if (c == last) begin
        chk(instOp == eOp, tag, "opcode", instOp, eOp);
        chk(instAddrA == eA, tag, "A address", instAddrA, eA);
        chk(instAddrB == eB, tag, "B address", instAddrB, eB);
        chk(instMod == eMod, tag, "modifier", instMod, eMod);
        chk(ip == AW'(eIp), err ? "R6" : "R2", "pointer", ip, eIp);
      end
    end
    mOp = eOp; mA = eA; mB = eB; mMod = eMod; mIp = eIp;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) begin memC[a] = 6'(a); memM[a] = 1'b0; end
    rstN = 1'b0; fetchStart = 1'b0; ipLoad = 1'b0; ipLoadValue = '0;
    memChar = '0; memMark = 1'b0;
    mIp = 0; mA = '0; mB = '0; mOp = '0; mMod = '0;

    placeInst(0,   5,  10, 3,  1, 1);  // R3 count 11
    placeInst(11,  6,  11, 9,  1, 1);  // R3 count 12
    placeInst(23,  7,  0,  0,  1, 1);  // R5 count 1
    placeInst(24,  8,  5,  17, 1, 1);  // R5 count 6
    placeInst(30,  10, 6,  23, 1, 1);  // R3 count 7
    placeInst(37,  20, 3,  31, 1, 1);  // R4 count 4
    placeInst(41,  36, 9,  37, 1, 1);  // R4 count 10
    placeInst(51,  36, 4,  43, 1, 1);  // R4 count 5
    placeInst(56,  9,  2,  47, 1, 1);  // R6 count 3
    placeInst(100, 11, 5,  13, 0, 1);  // R1 no opcode mark
    placeInst(120, 12, 12, 19, 1, 0);  // R7 unterminated
    placeInst(140, 13, 10, 29, 1, 1);  // R9 load during fetch
    placeInst(160, 20, 8,  41, 1, 1);  // R4 count 9
    placeInst(180, 20, 5,  53, 1, 1);  // R4 count 6 invalid for I/O

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(ip == '0, "R10", "reset pointer", ip, 0);
    chk(!instValid && !lenError && !busy, "R10", "reset strobes", {instValid, lenError, busy}, 0);
    chk(instAddrA == '0 && instAddrB == '0 && instMod == '0 && instOp == '0,
        "R10", "reset fields", instAddrA, 0);

    runFetch("R3", 0);
    runFetch("R3", 0);
    runFetch("R5", 0);
    runFetch("R5", 0);
    runFetch("R3", 0);
    runFetch("R4", 0);
    runFetch("R4", 0);
    runFetch("R4", 0);
    runFetch("R6", 0);
    chk(ip == AW'(56), "R6", "pointer held after error", ip, 56);
    loadIp(100);
    runFetch("R1", 0);
    loadIp(120);
    runFetch("R7", 0);
    loadIp(140);
    runFetch("R9", 1);
    chk(ip == AW'(151), "R9", "load during fetch ignored", ip, 151);
    loadIp(160);
    runFetch("R4", 0);
    loadIp(180);
    runFetch("R4", 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule